// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the command side of an SD/MMC host controller. Software programs an argument word and then writes a command word over a simple word-addressed register bus. That write launches a 48-bit command frame on the CMD line. The frame is shifted out one bit per SD-clock strobe, most significant bit first. After the frame, the unit listens for the card's reply when the command word asks for one. A reply can be a 48-bit short response or a 136-bit long response. The unit checks the reply and stores its payload in four response words, then raises write-one-to-clear interrupt flags.

The SD clock itself is generated elsewhere. The unit receives a one-cycle strobe `sd_stb_i` that marks each SD-clock bit period. On a strobe, the unit advances its output bit and samples `cmd_i`.

Two status flags control when software may issue a new command:
- Command inhibit covers the whole command and reply exchange.
- Data inhibit guards commands that carry a data phase or a busy response. It is released once the card lets DAT0 go high.

A self-clearing control bit aborts the command circuit.

Top module: `sdc_cmd_unit`

## Requirements
- R1: An accepted command write drives exactly 48 bits on `cmd_o`, one per strobe, MSB first, with `cmd_oe_o` high for exactly those bits and low otherwise. The bits are, in order:
  - start 0
  - transmission 1
  - the index from command-word bits 29:24
  - the 32-bit argument register
  - CRC7 (x^7+x^3+1, zero seed) over the first 40 bits
  - end bit 1
- R2: Command-word bits 17:16 select the reply.
  - 0: no reply. The command completes right after the frame, setting interrupt bit 0.
  - 1: a 136-bit reply.
  - 2 or 3: a 48-bit reply.
  - A reply is recognised from its 0 start bit after the frame.
- R3: For a 48-bit reply, response word 0 (address 2) receives reply bits 39:8, the card status.
- R4: A 136-bit reply is stored without its CRC byte. Words 0..3 (addresses 2..5) receive reply bits 39:8, 71:40, 103:72 and {8'h00, 127:104}.
- R5: When command-word bit 20 is set, a 48-bit reply whose bits 45:40 differ from the command index sets interrupt bit 19 instead of bit 0. When bit 20 is clear, the mismatch has no effect.
- R6: When command-word bit 19 is set, a reply whose bits 7:1 differ from the CRC7 of the covered bits sets interrupt bit 17 instead of bit 0. The covered bits are 47:8 for a short reply and 127:8 for a long one. When bit 19 is clear, the mismatch is ignored.
- R7: A reply whose last bit is 0 sets interrupt bit 18 instead of bit 0.
- R8: If no start bit is seen within 64 strobes after the frame, interrupt bit 16 is set and command inhibit is released.
- R9: Status bit 0 (address 6) is high from an accepted command write until completion, an error or an abort. A command write while it is high is dropped, and the command word reads back unchanged.
- R10: Status bit 1 is set when a command with bit 21 set or reply type 3 is accepted. It clears on a strobe where command inhibit is low and `dat0_i` is high. While it is set, commands of those kinds are dropped, but other commands are accepted.
- R11: Interrupt status (address 7) bits clear when 1 is written to them. A flag being set in the same cycle as its clear wins and stays set.
- R12: Writing 1 to control bit 0 (address 8) aborts the command circuit. On the next cycle `cmd_oe_o` and command inhibit are low. The bit reads 1 for that one cycle and 0 afterwards, and the aborted command raises no interrupt.
- R13: The register words are at these addresses, and all of them read zero after reset:
  - 0: argument
  - 1: command
  - 2..5: response
  - 6: status
  - 7: interrupt
  - 8: control

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| sd_stb_i | input | 1 | One SD-clock bit period elapsed |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe_o | output | 1 | CMD line output enable |
| cmd_i | input | 1 | CMD line input value |
| dat0_i | input | 1 | DAT0 line, low while the card is busy |

## Verification
The interrupt flag update has two sources that can act in the same cycle:
- software's write-one-to-clear of the command-complete bit
- hardware setting that same bit when a command finishes

The bench first measures how many cycles a no-reply command takes from its register write to completion. It then repeats the command and places a clear write exactly on the completion edge. The bit must read 1 afterwards, and a later clear must still remove it. A second collision pairs an incoming busy command with a held data inhibit: that command must be dropped while a plain command still goes through.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  localparam int FRAME_W = 48;
  localparam int LONG_W  = 136;
  localparam int HDR_W   = 8;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_LONG  = 2'd1,
    RSP_SHORT = 2'd2,
    RSP_BUSY  = 2'd3
  } rsp_e;

  localparam logic [3:0] A_ARG  = 4'd0;
  localparam logic [3:0] A_CMD  = 4'd1;
  localparam logic [3:0] A_RSP0 = 4'd2;
  localparam logic [3:0] A_RSP1 = 4'd3;
  localparam logic [3:0] A_RSP2 = 4'd4;
  localparam logic [3:0] A_RSP3 = 4'd5;
  localparam logic [3:0] A_STAT = 4'd6;
  localparam logic [3:0] A_IRQ  = 4'd7;
  localparam logic [3:0] A_CTRL = 4'd8;

  localparam int IRQ_DONE = 0;
  localparam int IRQ_TMO  = 16;
  localparam int IRQ_CRC  = 17;
  localparam int IRQ_END  = 18;
  localparam int IRQ_IDX  = 19;
  localparam logic [31:0] IRQ_MASK = 32'h000F_0001;

  localparam int CW_DATA = 21;
  localparam int CW_IDXC = 20;
  localparam int CW_CRCC = 19;

  function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_40(logic [39:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdc_crc7.sv
`timescale 1ns/1ps
module sdc_crc7
  import sdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc7_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sdc_cmd_tx.sv
`timescale 1ns/1ps
module sdc_cmd_tx
  import sdc_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic        stb_i,
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  output logic        cmd_o,
  output logic        oe_o,
  output logic        done_o
);
  localparam int CNT_W = $clog2(FW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [39:0]      body;
  logic [FW-1:0]    frame;
  logic [FW-1:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q, done_q;

  assign body  = {2'b01, idx_i, arg_i};
  assign frame = {body, crc7_40(body), 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (abort_i) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q  <= frame;
        cnt_q <= CNT_FULL;
        act_q <= 1'b1;
      end else if (act_q && stb_i) begin
        sh_q  <= {sh_q[FW-2:0], 1'b1};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_ONE) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cmd_o  = act_q ? sh_q[FW-1] : 1'b1;
  assign oe_o   = act_q;
  assign done_o = done_q;

  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> !cmd_o); // R1
  AST_TX_DONE_ENDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!oe_o && $past(oe_o))); // R1
endmodule

// File: rtl/sdc_cmd_rx.sv
`timescale 1ns/1ps
module sdc_cmd_rx
  import sdc_pkg::*;
#(
  parameter int LW       = LONG_W,
  parameter int SW       = FRAME_W,
  parameter int HW       = HDR_W,
  parameter int WAIT_MAX = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             long_i,
  input  logic             abort_i,
  input  logic             stb_i,
  input  logic             cmd_i,
  output logic             done_o,
  output logic             tmo_o,
  output logic [LW-HW-1:0] frame_o,
  output logic [6:0]       crc_o
);
  localparam int CNT_W = $clog2(LW + 1);
  localparam int WCN_W = $clog2(WAIT_MAX);
  localparam logic [CNT_W-1:0] LEN_L   = CNT_W'(LW);
  localparam logic [CNT_W-1:0] LEN_S   = CNT_W'(SW);
  localparam logic [CNT_W-1:0] CRC_LO  = CNT_W'(HW + 1);
  localparam logic [CNT_W-1:0] CRC_HIL = CNT_W'(LW - HW);
  localparam logic [CNT_W-1:0] CRC_HIS = CNT_W'(SW - HW);
  localparam logic [WCN_W-1:0] W_LAST  = WCN_W'(WAIT_MAX - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV} rx_st_e;

  rx_st_e           st_q;
  logic [LW-1:0]    sh_q;
  logic [CNT_W-1:0] cnt_q, n_nxt, len;
  logic [WCN_W-1:0] wcnt_q;
  logic             long_q, done_q, tmo_q;
  logic             bit_take, in_crc;

  assign len      = long_q ? LEN_L : LEN_S;
  assign n_nxt    = (st_q == RX_WAIT) ? CNT_W'(1) : cnt_q + 1'b1;
  assign bit_take = stb_i && ((st_q == RX_WAIT && !cmd_i) || st_q == RX_RECV);
  assign in_crc   = long_q ? (n_nxt >= CRC_LO && n_nxt <= CRC_HIL) : (n_nxt <= CRC_HIS);

  sdc_crc7 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm_i),
    .en_i   (bit_take && in_crc && !abort_i),
    .bit_i  (cmd_i),
    .crc_o  (crc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      wcnt_q <= '0;
      long_q <= 1'b0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else if (abort_i) begin
      st_q   <= RX_IDLE;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (arm_i) begin
          st_q   <= RX_WAIT;
          wcnt_q <= '0;
          long_q <= long_i;
        end
        RX_WAIT: if (stb_i) begin
          if (!cmd_i) begin
            st_q  <= RX_RECV;
            cnt_q <= CNT_W'(1);
            sh_q  <= {sh_q[LW-2:0], 1'b0};
          end else if (wcnt_q == W_LAST) begin
            tmo_q <= 1'b1;
            st_q  <= RX_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        RX_RECV: if (stb_i) begin
          sh_q  <= {sh_q[LW-2:0], cmd_i};
          cnt_q <= n_nxt;
          if (n_nxt == len) begin
            done_q <= 1'b1;
            st_q   <= RX_IDLE;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign tmo_o   = tmo_q;
  assign frame_o = sh_q[LW-HW-1:0];

  AST_RX_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && tmo_o)); // R8
  AST_RX_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (long_q ? !sh_q[LW-1] : !sh_q[SW-1])); // R2
endmodule

// File: rtl/sdc_cmd_unit.sv
`timescale 1ns/1ps
module sdc_cmd_unit
  import sdc_pkg::*;
#(
  parameter int WAIT_MAX = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        sd_stb_i,
  output logic        cmd_o,
  output logic        cmd_oe_o,
  input  logic        cmd_i,
  input  logic        dat0_i
);
  localparam int FR_W = LONG_W - HDR_W;

  logic [31:0]     arg_q, cmd_q, irq_q, irq_set, irq_clr;
  logic [31:0]     resp_q [4];
  logic            cmd_inh_q, dat_inh_q, rst_q;
  rsp_e            new_rsp, rsp_q;
  logic            wr_cmd, new_needs_dat, accept;
  logic            tx_done, rx_done, rx_tmo, fin;
  logic [FR_W-1:0] frame;
  logic [6:0]      rx_crc;
  logic            is_long, idx_err, crc_err, end_err;

  assign wr_cmd        = wr_i && (addr_i == A_CMD);
  assign new_rsp       = rsp_e'(wdata_i[17:16]);
  assign new_needs_dat = wdata_i[CW_DATA] || (new_rsp == RSP_BUSY);
  assign accept        = wr_cmd && !cmd_inh_q && !rst_q && !(dat_inh_q && new_needs_dat);
  assign rsp_q         = rsp_e'(cmd_q[17:16]);
  assign is_long       = (rsp_q == RSP_LONG);

  sdc_cmd_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .abort_i (rst_q),
    .stb_i   (sd_stb_i),
    .idx_i   (wdata_i[29:24]),
    .arg_i   (arg_q),
    .cmd_o   (cmd_o),
    .oe_o    (cmd_oe_o),
    .done_o  (tx_done)
  );

  sdc_cmd_rx #(.WAIT_MAX(WAIT_MAX)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (tx_done && rsp_q != RSP_NONE),
    .long_i  (is_long),
    .abort_i (rst_q),
    .stb_i   (sd_stb_i),
    .cmd_i   (cmd_i),
    .done_o  (rx_done),
    .tmo_o   (rx_tmo),
    .frame_o (frame),
    .crc_o   (rx_crc)
  );

  // reply checks, valid in the rx_done cycle
  assign end_err = !frame[0];
  assign crc_err = cmd_q[CW_CRCC] && (rx_crc != frame[7:1]);
  assign idx_err = cmd_q[CW_IDXC] && !is_long && (frame[45:40] != cmd_q[29:24]);
  assign fin     = (tx_done && rsp_q == RSP_NONE) || rx_done || rx_tmo;

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_DONE] = (tx_done && rsp_q == RSP_NONE) ||
                        (rx_done && !(idx_err || crc_err || end_err));
    irq_set[IRQ_TMO]  = rx_tmo;
    irq_set[IRQ_CRC]  = rx_done && crc_err;
    irq_set[IRQ_END]  = rx_done && end_err;
    irq_set[IRQ_IDX]  = rx_done && idx_err;
    irq_clr           = (wr_i && addr_i == A_IRQ) ? (wdata_i & IRQ_MASK) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q     <= '0;
      cmd_q     <= '0;
      irq_q     <= '0;
      cmd_inh_q <= 1'b0;
      dat_inh_q <= 1'b0;
      rst_q     <= 1'b0;
      for (int i = 0; i < 4; i++) resp_q[i] <= '0;
    end else begin
      if (wr_i && addr_i == A_ARG) arg_q <= wdata_i;
      if (accept) cmd_q <= wdata_i;
      rst_q <= wr_i && (addr_i == A_CTRL) && wdata_i[0];
      irq_q <= (irq_q & ~irq_clr) | irq_set;
      if (accept)                cmd_inh_q <= 1'b1;
      else if (rst_q || fin)     cmd_inh_q <= 1'b0;
      if (accept && new_needs_dat) dat_inh_q <= 1'b1;
      else if (dat_inh_q && !cmd_inh_q && sd_stb_i && dat0_i) dat_inh_q <= 1'b0;
      if (rx_done) begin
        resp_q[0] <= frame[39:8];
        if (is_long) begin
          resp_q[1] <= frame[71:40];
          resp_q[2] <= frame[103:72];
          resp_q[3] <= {8'h00, frame[127:104]};
        end
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_ARG:   rdata_o = arg_q;
      A_CMD:   rdata_o = cmd_q;
      A_RSP0:  rdata_o = resp_q[0];
      A_RSP1:  rdata_o = resp_q[1];
      A_RSP2:  rdata_o = resp_q[2];
      A_RSP3:  rdata_o = resp_q[3];
      A_STAT:  rdata_o = {30'b0, dat_inh_q, cmd_inh_q};
      A_IRQ:   rdata_o = irq_q;
      A_CTRL:  rdata_o = {31'b0, rst_q};
      default: rdata_o = '0;
    endcase
  end

  AST_OE_NEEDS_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> cmd_inh_q); // R9
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && cmd_inh_q) |=> $stable(cmd_q)); // R9
  AST_DAT_HELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_inh_q && !dat0_i) |=> dat_inh_q); // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set[IRQ_DONE] |=> irq_q[IRQ_DONE]); // R11
  AST_ABORT_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> (!cmd_inh_q && !cmd_oe_o)); // R12
endmodule

// File: tb/sim_sdc_cmd_unit.sv
`timescale 1ns/1ps
module sim_sdc_cmd_unit;
  localparam logic [31:0] F_DATA = 32'h1 << 21;
  localparam logic [31:0] F_IDX  = 32'h1 << 20;
  localparam logic [31:0] F_CRC  = 32'h1 << 19;
  localparam logic [31:0] T_LONG = 32'h1 << 16;
  localparam logic [31:0] T_SHRT = 32'h2 << 16;
  localparam logic [31:0] T_BUSY = 32'h3 << 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, stb = 1'b1, cmd_in = 1'b1, dat0 = 1'b1;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic cmd_out, cmd_oe;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  sdc_cmd_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sd_stb_i(stb), .cmd_o(cmd_out), .cmd_oe_o(cmd_oe),
    .cmd_i(cmd_in), .dat0_i(dat0)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] b_crc(input logic [135:0] d, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = c[6] ^ d[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] st,
                                            input logic bad_crc, input logic bad_end);
    logic [39:0] b = {2'b00, idx, st};
    logic [6:0] c = b_crc({96'b0, b}, 40) ^ (bad_crc ? 7'h01 : 7'h00);
    return {88'b0, b, c, ~bad_end};
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [31:0] fl);
    logic [47:0] got, exp;
    logic [39:0] b;
    int oe_hi = 0;
    b = {2'b01, idx, arg};
    exp = {b, b_crc({96'b0, b}, 40), 1'b1};
    bus_wr(4'd0, arg);
    bus_wr(4'd1, fl | (32'(idx) << 24));
    for (int i = 47; i >= 0; i--) begin
      got[i] = cmd_out;
      if (cmd_oe) oe_hi++;
      @(negedge clk);
    end
    check("R1", "frame hi", {16'b0, got[47:32]}, {16'b0, exp[47:32]});
    check("R1", "frame lo", got[31:0], exp[31:0]);
    check("R1", "oe width", 32'(oe_hi), 32'd48);
    check("R1", "oe after", {31'b0, cmd_oe}, 32'd0);
  endtask

  task automatic respond(input logic [135:0] frm, input int len, input int gap);
    repeat (gap) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = frm[i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic wait_irq(input logic [31:0] mask, output logic [31:0] v);
    for (int k = 0; k < 200; k++) begin
      bus_rd(4'd7, v);
      if ((v & mask) != 0) break;
      @(negedge clk);
    end
  endtask

  task automatic clear_irq();
    bus_wr(4'd7, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      bus_rd(4'(a), v);
      check("R13", "reset value", v, 32'd0);
    end
    check("R1", "idle oe", {31'b0, cmd_oe}, 32'd0);
    check("R1", "idle line", {31'b0, cmd_out}, 32'd1);
  endtask

  task automatic t_no_reply();
    logic [31:0] v;
    send_cmd(6'd0, 32'h1234_5678, 32'h0);
    wait_irq(32'hFFFF_FFFF, v);
    check("R2", "no-reply irq", v, 32'h1);
    bus_rd(4'd6, v);
    check("R9", "inhibit released", v, 32'd0);
    clear_irq();
    bus_rd(4'd7, v);
    check("R11", "w1c clears", v, 32'd0);
  endtask

  task automatic t_short(input int gap);
    logic [31:0] v;
    send_cmd(6'd17, 32'h0000_0200, T_SHRT | F_IDX | F_CRC);
    bus_rd(4'd6, v);
    check("R9", "inhibit during reply wait", v, 32'd1);
    respond(mk_short(6'd17, 32'hCAFE_F00D, 1'b0, 1'b0), 48, gap);
    wait_irq(32'hFFFF_FFFF, v);
    check("R3", "short irq", v, 32'h1);
    bus_rd(4'd2, v);
    check("R3", "card status", v, 32'hCAFE_F00D);
    clear_irq();
  endtask

  task automatic t_long();
    logic [31:0] v;
    logic [119:0] pl = {24'hA1B2C3, 32'h0102_0304, 32'h5566_7788, 32'h99AA_BBCC};
    logic [135:0] frm = {8'h3F, pl, b_crc({16'b0, pl}, 120), 1'b1};
    send_cmd(6'd2, 32'h0, T_LONG | F_CRC);
    respond(frm, 136, 3);
    wait_irq(32'hFFFF_FFFF, v);
    check("R4", "long irq", v, 32'h1);
    bus_rd(4'd2, v); check("R4", "word0", v, pl[31:0]);
    bus_rd(4'd3, v); check("R4", "word1", v, pl[63:32]);
    bus_rd(4'd4, v); check("R4", "word2", v, pl[95:64]);
    bus_rd(4'd5, v); check("R4", "word3", v, {8'h00, pl[119:96]});
    clear_irq();
  endtask

  task automatic t_errors();
    logic [31:0] v;
    send_cmd(6'd13, 32'h0, T_SHRT | F_IDX);
    respond(mk_short(6'd14, 32'h1, 1'b0, 1'b0), 48, 2);
    wait_irq(32'hFFFF_FFFF, v);
    check("R5", "index error", v, 32'h1 << 19);
    clear_irq();
    send_cmd(6'd13, 32'h0, T_SHRT);
    respond(mk_short(6'd14, 32'h1, 1'b0, 1'b0), 48, 2);
    wait_irq(32'hFFFF_FFFF, v);
    check("R5", "index unchecked", v, 32'h1);
    clear_irq();
    send_cmd(6'd13, 32'h0, T_SHRT | F_CRC);
    respond(mk_short(6'd13, 32'h2, 1'b1, 1'b0), 48, 2);
    wait_irq(32'hFFFF_FFFF, v);
    check("R6", "crc error", v, 32'h1 << 17);
    clear_irq();
    send_cmd(6'd13, 32'h0, T_SHRT);
    respond(mk_short(6'd13, 32'h3, 1'b1, 1'b0), 48, 2);
    wait_irq(32'hFFFF_FFFF, v);
    check("R6", "crc unchecked", v, 32'h1);
    clear_irq();
    send_cmd(6'd13, 32'h0, T_SHRT);
    respond(mk_short(6'd13, 32'h4, 1'b0, 1'b1), 48, 2);
    wait_irq(32'hFFFF_FFFF, v);
    check("R7", "end bit error", v, 32'h1 << 18);
    clear_irq();
  endtask

  task automatic t_timeout_and_drop();
    logic [31:0] v;
    int oe_seen = 0;
    bus_wr(4'd0, 32'h0);
    bus_wr(4'd1, T_SHRT | (32'd8 << 24));
    bus_wr(4'd1, 32'd9 << 24);
    bus_rd(4'd1, v);
    check("R9", "dropped write, cmd word", v, T_SHRT | (32'd8 << 24));
    wait_irq(32'hFFFF_FFFF, v);
    check("R8", "timeout irq", v, 32'h1 << 16);
    bus_rd(4'd6, v);
    check("R8", "inhibit after timeout", v, 32'd0);
    for (int k = 0; k < 20; k++) begin
      if (cmd_oe) oe_seen++;
      @(negedge clk);
    end
    check("R9", "no queued frame", 32'(oe_seen), 32'd0);
    clear_irq();
  endtask

  task automatic t_busy();
    logic [31:0] v;
    dat0 = 1'b0;
    send_cmd(6'd12, 32'h0, T_BUSY | F_IDX | F_CRC);
    respond(mk_short(6'd12, 32'h900, 1'b0, 1'b0), 48, 2);
    wait_irq(32'hFFFF_FFFF, v);
    check("R10", "busy reply irq", v, 32'h1);
    bus_rd(4'd6, v);
    check("R10", "data inhibit held", v, 32'd2);
    clear_irq();
    bus_wr(4'd1, T_BUSY | (32'd7 << 24));
    bus_rd(4'd1, v);
    check("R10", "busy cmd dropped", v, T_BUSY | F_IDX | F_CRC | (32'd12 << 24));
    check("R10", "no frame for dropped", {31'b0, cmd_oe}, 32'd0);
    send_cmd(6'd0, 32'h0, 32'h0);
    wait_irq(32'hFFFF_FFFF, v);
    check("R10", "plain cmd accepted", v, 32'h1);
    clear_irq();
    dat0 = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_rd(4'd6, v);
    check("R10", "data inhibit released", v, 32'd0);
    bus_wr(4'd0, 32'h0);
    bus_wr(4'd1, F_DATA | 32'd0);
    bus_rd(4'd6, v);
    check("R10", "data cmd sets both", v, 32'd3);
    wait_irq(32'hFFFF_FFFF, v);
    @(negedge clk); @(negedge clk);
    bus_rd(4'd6, v);
    check("R10", "data cmd end", v, 32'd0);
    clear_irq();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    int n = 0;
    bus_wr(4'd0, 32'h0);
    bus_wr(4'd1, 32'h0);
    for (int k = 0; k < 200; k++) begin
      bus_rd(4'd7, v);
      if (v[0]) break;
      @(negedge clk);
      n++;
    end
    clear_irq();
    bus_wr(4'd0, 32'h0);
    bus_wr(4'd1, 32'h0);
    repeat (n - 1) @(negedge clk);
    bus_wr(4'd7, 32'h1);
    bus_rd(4'd7, v);
    check("R11", "set wins over clear", v, 32'h1);
    bus_wr(4'd7, 32'h1);
    bus_rd(4'd7, v);
    check("R11", "later clear", v, 32'h0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    bus_wr(4'd0, 32'h0);
    bus_wr(4'd1, T_SHRT | (32'd3 << 24));
    repeat (10) @(negedge clk);
    bus_wr(4'd8, 32'h1);
    bus_rd(4'd8, v);
    check("R12", "reset bit visible", v, 32'd1);
    @(negedge clk);
    bus_rd(4'd8, v);
    check("R12", "reset bit self-clears", v, 32'd0);
    bus_rd(4'd6, v);
    check("R12", "inhibit cleared", v, 32'd0);
    check("R12", "line released", {31'b0, cmd_oe}, 32'd0);
    repeat (120) @(negedge clk);
    bus_rd(4'd7, v);
    check("R12", "no irq after abort", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_reply();
    t_short(3);
    t_short(40);
    t_long();
    t_errors();
    t_timeout_and_drop();
    t_busy();
    t_collide();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule